// File: doc/BRIEF.md
# Parallel Port EPP Cycle Timeout Detector

This block watches each enhanced-parallel-port (EPP) data or address cycle that the host starts, and waits for the peripheral's wait/acknowledge handshake. If the peripheral answers in time, the cycle closes normally and, on a read, returns the peripheral's byte. If it stays silent for a fixed time, the block closes the cycle itself, drops its strobe, returns all-ones on a read, and sets a sticky timeout flag.

The flag is seen by software as bit 0 of the port's status register. A parameter picks how the flag is cleared: by writing a one to that bit, or by reading the status register. Outside EPP mode the bit always reads as one. While the flag is pending, standard-mode (compatibility) cycles are held off. The time limit is set in microseconds and converted to clock cycles from a clock-frequency parameter in MHz.

Top module: `epp_tmo_unit`

## Requirements
- R1: A cycle starts only when `cyc_req` is high at a clock edge while `epp_mode` is high and no cycle is in progress; `strobe` is then high from the next cycle on. A request outside EPP mode, or during a running cycle, is ignored.
- R2: With TMO = CLK_MHZ*TMO_US, if `per_wait` is first seen high at the k-th clock edge after the start edge with 1 <= k <= TMO, the cycle ends at that edge: `strobe` falls, `cyc_done` is high for exactly one cycle, and `cyc_rdata` holds `per_data` on a read cycle (`cyc_rd`=1) or 0x00 on a write cycle.
- R3: If `per_wait` stays low through the TMO-th edge after the start edge, the cycle ends at that edge with `strobe` low, a one-cycle `cyc_done`, `cyc_rdata`=0xFF on a read (0x00 on a write) and the timeout flag set; `strobe` is never high for more than TMO cycles.
- R4: In EPP mode `tmo_bit` (status bit 0) equals the timeout flag, so it reads 0 when no timeout is pending; with `epp_mode` low it reads 1. The flag itself is kept across mode changes.
- R5: With CLR_ON_READ=0, a status write (`stat_wr`) with `stat_wbit0`=1 clears the flag; a write with `stat_wbit0`=0 and a status read (`stat_rd`) leave it unchanged.
- R6: With CLR_ON_READ=1, a status read clears the flag; status writes of either bit value leave it unchanged.
- R7: A timeout and a clear at the same clock edge leave the flag set.
- R8: `spp_go` is high in the cycle after an edge where `spp_req` was high and the flag was clear, and low after an edge where the flag was set.
- R9: During reset `strobe`, `cyc_done`, `spp_go` are 0, `cyc_rdata` is 0x00 and `tmo_bit` is 1; the flag is clear after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| epp_mode | input | 1 | Port is configured for EPP operation |
| cyc_req | input | 1 | Host request to start an EPP cycle |
| cyc_rd | input | 1 | Requested cycle is a read (1) or write (0) |
| per_wait | input | 1 | Peripheral handshake response |
| per_data | input | DW | Byte returned by the peripheral on a read |
| stat_wr | input | 1 | Status register write strobe |
| stat_wbit0 | input | 1 | Bit 0 of the status write data |
| stat_rd | input | 1 | Status register read strobe |
| spp_req | input | 1 | Request for a standard-mode cycle |
| strobe | output | 1 | EPP cycle strobe, high while a cycle runs |
| cyc_done | output | 1 | One-cycle pulse when a cycle ends |
| cyc_rdata | output | DW | Data of the finished cycle |
| tmo_bit | output | 1 | Status bit 0 as seen by software |
| spp_go | output | 1 | Standard-mode cycle granted |

## Verification
The hardest case to reach is a timeout landing on the very edge where software clears the flag, since it needs the clear strobes on exactly the TMO-th edge after the start. The bench uses a short limit, counts edges itself from the start edge, and drives both clear strobes only for that one edge. The response delay is swept over every value from immediate through just past the limit, in both directions, so the edge where a late answer still wins and the edge where the timeout takes over are both hit.

// File: rtl/epp_tmo_pkg.sv
package epp_tmo_pkg;
  typedef enum logic [0:0] {
    CYC_IDLE = 1'b0,
    CYC_BUSY = 1'b1
  } cyc_state_e;

  function automatic int tmo_cycles(input int mhz, input int usec);
    return mhz * usec;
  endfunction
endpackage

// File: rtl/epp_tmo_timer.sv
module epp_tmo_timer #(
  parameter int LIMIT = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/epp_cyc_ctl.sv
module epp_cyc_ctl
  import epp_tmo_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          epp_mode,
  input  logic          cyc_req,
  input  logic          cyc_rd,
  input  logic          per_wait,
  input  logic [DW-1:0] per_data,
  input  logic          expired,
  output logic          tmr_clr,
  output logic          tmr_run,
  output logic          tmo_evt,
  output logic          strobe,
  output logic          cyc_done,
  output logic [DW-1:0] cyc_rdata
);
  cyc_state_e st_q;
  logic       rd_q;
  logic       start, fin_ok, fin_to;

  assign start   = (st_q == CYC_IDLE) && cyc_req && epp_mode;
  assign fin_ok  = (st_q == CYC_BUSY) && per_wait;
  assign fin_to  = (st_q == CYC_BUSY) && !per_wait && expired;
  assign tmr_clr = start;
  assign tmr_run = (st_q == CYC_BUSY);
  assign tmo_evt = fin_to;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= CYC_IDLE;
      rd_q      <= 1'b0;
      strobe    <= 1'b0;
      cyc_done  <= 1'b0;
      cyc_rdata <= '0;
    end else begin
      cyc_done <= fin_ok || fin_to;
      if (start) begin
        st_q   <= CYC_BUSY;
        rd_q   <= cyc_rd;
        strobe <= 1'b1;
      end else if (fin_ok || fin_to) begin
        st_q   <= CYC_IDLE;
        strobe <= 1'b0;
        if (!rd_q)
          cyc_rdata <= '0;
        else if (fin_ok)
          cyc_rdata <= per_data;
        else
          cyc_rdata <= '1;
      end
    end
  end
endmodule

// File: rtl/epp_tmo_flag.sv
module epp_tmo_flag #(
  parameter bit CLR_ON_READ = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic epp_mode,
  input  logic stat_wr,
  input  logic stat_wbit0,
  input  logic stat_rd,
  input  logic spp_req,
  output logic flag_q,
  output logic tmo_bit,
  output logic spp_go
);
  logic clr, flag_d;

  assign clr    = CLR_ON_READ ? stat_rd : (stat_wr && stat_wbit0);
  assign flag_d = set ? 1'b1 : (clr ? 1'b0 : flag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      tmo_bit <= 1'b1;
      spp_go  <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      tmo_bit <= epp_mode ? flag_d : 1'b1;
      spp_go  <= spp_req && !flag_q;
    end
  end
endmodule

// File: rtl/epp_tmo_unit.sv
module epp_tmo_unit
  import epp_tmo_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CLK_MHZ     = 250,
  parameter int TMO_US      = 10,
  parameter bit CLR_ON_READ = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          epp_mode,
  input  logic          cyc_req,
  input  logic          cyc_rd,
  input  logic          per_wait,
  input  logic [DW-1:0] per_data,
  input  logic          stat_wr,
  input  logic          stat_wbit0,
  input  logic          stat_rd,
  input  logic          spp_req,
  output logic          strobe,
  output logic          cyc_done,
  output logic [DW-1:0] cyc_rdata,
  output logic          tmo_bit,
  output logic          spp_go
);
  localparam int TMO_CYC = tmo_cycles(CLK_MHZ, TMO_US);

  logic tmr_clr, tmr_run, expired, tmo_evt, flag_q;

  epp_tmo_timer #(.LIMIT(TMO_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .run     (tmr_run),
    .expired (expired)
  );

  epp_cyc_ctl #(.DW(DW)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .epp_mode  (epp_mode),
    .cyc_req   (cyc_req),
    .cyc_rd    (cyc_rd),
    .per_wait  (per_wait),
    .per_data  (per_data),
    .expired   (expired),
    .tmr_clr   (tmr_clr),
    .tmr_run   (tmr_run),
    .tmo_evt   (tmo_evt),
    .strobe    (strobe),
    .cyc_done  (cyc_done),
    .cyc_rdata (cyc_rdata)
  );

  epp_tmo_flag #(.CLR_ON_READ(CLR_ON_READ)) u_flag (
    .clk        (clk),
    .rst        (rst),
    .set        (tmo_evt),
    .epp_mode   (epp_mode),
    .stat_wr    (stat_wr),
    .stat_wbit0 (stat_wbit0),
    .stat_rd    (stat_rd),
    .spp_req    (spp_req),
    .flag_q     (flag_q),
    .tmo_bit    (tmo_bit),
    .spp_go     (spp_go)
  );
endmodule

// File: rtl/epp_tmo_chk.sv
module epp_tmo_chk #(
  parameter int TMO_CYC     = 2500,
  parameter bit CLR_ON_READ = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic epp_mode,
  input logic strobe,
  input logic cyc_done,
  input logic tmo_bit,
  input logic spp_req,
  input logic spp_go,
  input logic stat_wr,
  input logic stat_wbit0,
  input logic stat_rd,
  input logic flag_q,
  input logic tmo_evt
);
  int unsigned hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= 0;
    else if (strobe) hi_cnt <= hi_cnt + 1;
    else hi_cnt <= 0;
  end

  // R3: the strobe never outlasts the time limit
  always_comb begin
    if (!rst && strobe)
      p_strobe_len_r3: assert (hi_cnt < TMO_CYC);
  end

  p_done_ends_r2: assert property (@(posedge clk) disable iff (rst)
    cyc_done |-> !strobe);

  p_tmo_sets_r3: assert property (@(posedge clk) disable iff (rst)
    tmo_evt |=> flag_q);

  p_nonepp_one_r4: assert property (@(posedge clk) disable iff (rst)
    !epp_mode |=> tmo_bit);

  p_wr_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (!CLR_ON_READ && stat_wr && stat_wbit0 && !tmo_evt) |=> !flag_q);

  p_rd_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (CLR_ON_READ && stat_rd && !tmo_evt) |=> !flag_q);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (tmo_evt && (stat_rd || stat_wr)) |=> flag_q);

  p_spp_block_r8: assert property (@(posedge clk) disable iff (rst)
    (spp_req && flag_q) |=> !spp_go);
endmodule

bind epp_tmo_unit epp_tmo_chk #(.TMO_CYC(TMO_CYC), .CLR_ON_READ(CLR_ON_READ)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .epp_mode   (epp_mode),
  .strobe     (strobe),
  .cyc_done   (cyc_done),
  .tmo_bit    (tmo_bit),
  .spp_req    (spp_req),
  .spp_go     (spp_go),
  .stat_wr    (stat_wr),
  .stat_wbit0 (stat_wbit0),
  .stat_rd    (stat_rd),
  .flag_q     (flag_q),
  .tmo_evt    (tmo_evt)
);

// File: tb/test_epp_tmo_unit.sv
module test_epp_tmo_unit;
  localparam int DW  = 8;
  localparam int MHZ = 1;
  localparam int US  = 6;
  localparam int TMO = MHZ * US;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic epp_mode = 1'b0, cyc_req = 1'b0, cyc_rd = 1'b0, per_wait = 1'b0;
  logic [DW-1:0] per_data = '0;
  logic stat_wr = 1'b0, stat_wbit0 = 1'b0, stat_rd = 1'b0, spp_req = 1'b0;

  logic a_strobe, a_done, a_tmo, a_go, b_strobe, b_done, b_tmo, b_go;
  logic [DW-1:0] a_rdata, b_rdata;

  int checks = 0, errors = 0, cyc_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  epp_tmo_unit #(.DW(DW), .CLK_MHZ(MHZ), .TMO_US(US), .CLR_ON_READ(1'b0)) i_epp_tmo_unit (
    .clk(clk), .rst(rst), .epp_mode(epp_mode), .cyc_req(cyc_req), .cyc_rd(cyc_rd),
    .per_wait(per_wait), .per_data(per_data), .stat_wr(stat_wr), .stat_wbit0(stat_wbit0),
    .stat_rd(stat_rd), .spp_req(spp_req), .strobe(a_strobe), .cyc_done(a_done),
    .cyc_rdata(a_rdata), .tmo_bit(a_tmo), .spp_go(a_go));

  epp_tmo_unit #(.DW(DW), .CLK_MHZ(MHZ), .TMO_US(US), .CLR_ON_READ(1'b1)) i_epp_tmo_unit_rc (
    .clk(clk), .rst(rst), .epp_mode(epp_mode), .cyc_req(cyc_req), .cyc_rd(cyc_rd),
    .per_wait(per_wait), .per_data(per_data), .stat_wr(stat_wr), .stat_wbit0(stat_wbit0),
    .stat_rd(stat_rd), .spp_req(spp_req), .strobe(b_strobe), .cyc_done(b_done),
    .cyc_rdata(b_rdata), .tmo_bit(b_tmo), .spp_go(b_go));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (!finished && cyc_cnt > 50000) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc_cnt);
      summary();
    end
  end

  // clear both instances' flags in one cycle (write-one and read together)
  task automatic clear_both();
    @(negedge clk);
    stat_wr = 1'b1; stat_wbit0 = 1'b1; stat_rd = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0; stat_wbit0 = 1'b0; stat_rd = 1'b0;
  endtask

  // d = 0: peripheral never answers; clr_last: clear strobes on the TMO-th edge
  task automatic run_cycle(input bit rd, input int d, input logic [DW-1:0] data,
                           input bit clr_last);
    int  end_n = -1;
    int  exp_n;
    bit  exp_to;
    logic [DW-1:0] exp_d;
    exp_to = (d == 0) || (d > TMO);
    exp_n  = exp_to ? TMO : d;
    exp_d  = !rd ? '0 : (exp_to ? '1 : data);
    @(negedge clk);
    cyc_req = 1'b1; cyc_rd = rd; per_wait = 1'b0; per_data = data;
    @(negedge clk);
    cyc_req = 1'b0;
    chk(a_strobe && b_strobe, "R1 strobe after start", a_strobe, 1);
    for (int n = 1; n <= TMO + 2; n++) begin
      per_wait = (d != 0) && (n >= d);
      cyc_req  = (n == 2);
      if (clr_last && n == TMO) begin
        stat_wr = 1'b1; stat_wbit0 = 1'b1; stat_rd = 1'b1;
      end
      @(negedge clk);
      stat_wr = 1'b0; stat_wbit0 = 1'b0; stat_rd = 1'b0; cyc_req = 1'b0;
      if (!a_strobe && end_n < 0) begin
        end_n = n;
        break;
      end
    end
    per_wait = 1'b0;
    chk(end_n == exp_n, exp_to ? "R3 timeout edge" : "R2 response edge", end_n, exp_n);
    chk(a_done && b_done, "R2 done pulse", a_done, 1);
    chk(a_rdata == exp_d && b_rdata == exp_d,
        exp_to ? "R3 read data on timeout" : "R2 read data", a_rdata, exp_d);
    chk(a_tmo == exp_to && b_tmo == exp_to, exp_to ? "R3 flag set" : "R4 flag clear",
        a_tmo, exp_to);
    @(negedge clk);
    chk(!a_done && !b_done && !a_strobe, "R2 done single cycle", a_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset values
    chk(!a_strobe && !a_done && !a_go && a_rdata == 0, "R9 reset outputs", a_rdata, 0);
    chk(a_tmo && b_tmo, "R9 tmo_bit in reset", a_tmo, 1);
    rst = 1'b0;

    // R1 / R4: outside EPP mode
    @(negedge clk);
    cyc_req = 1'b1;
    @(negedge clk);
    cyc_req = 1'b0;
    chk(!a_strobe && !b_strobe, "R1 request ignored outside EPP", a_strobe, 0);
    chk(a_tmo && b_tmo, "R4 non-EPP reads 1", a_tmo, 1);

    epp_mode = 1'b1;
    @(negedge clk);
    chk(!a_tmo && !b_tmo, "R4 EPP no pending reads 0 (R9 flag clear)", a_tmo, 0);

    // sweep of response delays, both directions
    for (int rd = 0; rd < 2; rd++) begin
      for (int d = 0; d <= TMO + 2; d++) begin
        run_cycle(rd[0], d, DW'(8'h30 + 8'(d * 7 + rd)), 1'b0);
        clear_both();
        @(negedge clk);
        chk(!a_tmo && !b_tmo, "R5 R6 cleared after sweep step", a_tmo, 0);
      end
    end

    // R4: flag retained across mode change
    run_cycle(1'b1, 0, 8'h5A, 1'b0);
    epp_mode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(a_tmo && b_tmo, "R4 non-EPP reads 1 with flag", a_tmo, 1);
    epp_mode = 1'b1;
    @(negedge clk);
    chk(a_tmo && b_tmo, "R4 flag retained", a_tmo, 1);

    // R8: standard cycles blocked while flag pending
    spp_req = 1'b1;
    @(negedge clk);
    chk(!a_go && !b_go, "R8 spp blocked", a_go, 0);

    // R5 / R6: ineffective clears
    stat_wr = 1'b1; stat_wbit0 = 1'b0; spp_req = 1'b0;
    @(negedge clk);
    stat_wr = 1'b0;
    @(negedge clk);
    chk(a_tmo, "R5 write zero keeps flag", a_tmo, 1);
    chk(b_tmo, "R6 write zero keeps flag", b_tmo, 1);
    stat_wr = 1'b1; stat_wbit0 = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0; stat_wbit0 = 1'b0;
    @(negedge clk);
    chk(!a_tmo, "R5 write one clears", a_tmo, 0);
    chk(b_tmo, "R6 write one ignored", b_tmo, 1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    @(negedge clk);
    chk(!b_tmo, "R6 read clears", b_tmo, 0);
    run_cycle(1'b0, 0, 8'h00, 1'b0);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    @(negedge clk);
    chk(a_tmo, "R5 read ignored", a_tmo, 1);
    chk(!b_tmo, "R6 read clears again", b_tmo, 0);
    clear_both();

    // R8: granted when clear
    spp_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(a_go && b_go, "R8 spp granted", a_go, 1);
    spp_req = 1'b0;
    @(negedge clk);
    chk(!a_go, "R8 grant follows request", a_go, 0);

    // R7: timeout and clear on the same edge
    run_cycle(1'b1, 0, 8'h11, 1'b1);
    chk(a_tmo && b_tmo, "R7 set wins over clear", a_tmo, 1);
    clear_both();

    finished = 1'b1;
    summary();
  end
endmodule